// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block turns a parallel word into a bit stream. It has a chain of stages, eight by default, and all of them run on one system clock. A level-sensitive mode pin picks between two actions. When the pin is low, the stages copy the parallel word. When the pin is high, the chain moves one place toward its output on each rising edge of a gated tick.

The gated tick is the OR of two interchangeable pins, a tick pin and a tick-hold pin. A rising edge of either pin produces a shift, provided the other pin is low at the time. While either pin stays high, the chain holds.

The mode, tick, tick-hold and serial-in pins each pass through a two-flop synchroniser. An edge of the gated tick is found by comparing the synchronised OR value against its value one cycle earlier. The serial output comes straight from the last stage's flop, and a second output carries its complement. The controlling logic must raise tick-hold only while tick is high, so that raising it does not cause an unwanted shift.

Top module: `psr_shift_reg`

## Requirements
- R1: `sdout_o` always equals the last stage (stage H, index N-1), and `sdout_n_o` is always its inverse.
- R2: After `rst_ni` is asserted, every stage is 0, so `sdout_o` is 0 and `sdout_n_o` is 1.
- R3: While `mode_i` is 0 (load), every stage takes its parallel bit: `par_i[0]` goes to stage A and `par_i[N-1]` goes to stage H. This happens whatever the levels of `tick_i`, `tick_hold_i` and `sdin_i`.
- R4: A 0-to-1 change of `tick_i`, with `tick_hold_i` low and `mode_i` at 1, shifts the chain once. Stage A takes `sdin_i` and each other stage takes the old value of the stage before it.
- R5: When `mode_i` is 1 and no gated-tick rising edge occurs, the stages hold. This includes the falling edge of the tick. With `mode_i` at 1, `par_i` has no effect.
- R6: While `tick_hold_i` is high, the stages hold no matter how `tick_i` toggles. Lowering `tick_hold_i` while `tick_i` is low causes no shift.
- R7: A 0-to-1 change of `tick_hold_i` while `tick_i` is low shifts the chain exactly as in R4.
- R8: If a synchronised load and a detected gated-tick edge fall in the same system cycle, the load wins and no shift is applied.
- R9: A pin change first shows at the outputs after the third rising `clk_i` edge that follows it: two synchroniser flops, then the stage register. After only two edges, the outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_i | input | 1 | 1 = shift mode, 0 = parallel load (level) |
| tick_i | input | 1 | Shift tick, OR-gated with tick_hold_i |
| tick_hold_i | input | 1 | Tick hold; interchangeable with tick_i |
| sdin_i | input | 1 | Serial data into stage A |
| par_i | input | N (8) | Parallel word; bit 0 is stage A |
| sdout_o | output | 1 | Last stage value |
| sdout_n_o | output | 1 | Complement of last stage |

## Verification
On every cycle, the assertions check four things: the outputs track the last stage, a synchronised load copies the parallel word, a detected edge moves the chain by one place, and the stages stay frozen when there is no load and no edge. They also check that a held tick-hold never produces an edge.

Some behaviour can only be shown by the bench scenarios, because it depends on the sequence of pin activity. These are the three-edge latency, a load winning over a same-cycle edge, tick-hold acting as a tick, and whole words shifted out bit by bit.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef struct packed {
    logic mode;
    logic tick;
    logic hold;
    logic sdin;
  } psr_ctl_t;

  localparam int unsigned CTL_W = $bits(psr_ctl_t);
  // idle: shift mode, ticks low
  localparam psr_ctl_t CTL_IDLE = '{mode: 1'b1, tick: 1'b0, hold: 1'b0, sdin: 1'b0};
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned DEPTH  = 2,
  parameter logic [W-1:0] RST_V = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    chain_q[g] <= RST_V;
      else if (g == 0) chain_q[g] <= d_i;
      else            chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[DEPTH-1];
endmodule

// File: rtl/psr_gate_edge.sv
module psr_gate_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_s_i,
  input  logic hold_s_i,
  output logic rise_o
);
  logic gate_now;
  logic gate_q;

  assign gate_now = tick_s_i | hold_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= 1'b0;
    else         gate_q <= gate_now;
  end

  assign rise_o = gate_now & ~gate_q;
endmodule

// File: rtl/psr_stages.sv
module psr_stages #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic         sdin_i,
  input  logic [N-1:0] par_i,
  output logic [N-1:0] stg_o
);
  logic [N-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      stg_q <= '0;
    else if (load_i)  stg_q <= par_i;  // load overrides shift
    else if (shift_i) stg_q <= {stg_q[N-2:0], sdin_i};
  end

  assign stg_o = stg_q;
endmodule

// File: rtl/psr_shift_reg.sv
module psr_shift_reg #(
  parameter int unsigned N           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         tick_i,
  input  logic         tick_hold_i,
  input  logic         sdin_i,
  input  logic [N-1:0] par_i,
  output logic         sdout_o,
  output logic         sdout_n_o
);
  import psr_pkg::*;

  psr_ctl_t     ctl_raw;
  psr_ctl_t     ctl_s;
  logic         mode_s;
  logic         tick_s;
  logic         hold_s;
  logic         sdin_s;
  logic         rise;
  logic [N-1:0] stg_q;

  assign ctl_raw = '{mode: mode_i, tick: tick_i, hold: tick_hold_i, sdin: sdin_i};

  psr_sync #(
    .W     (CTL_W),
    .DEPTH (SYNC_STAGES),
    .RST_V (CTL_IDLE)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ctl_raw),
    .q_o    (ctl_s)
  );

  assign mode_s = ctl_s.mode;
  assign tick_s = ctl_s.tick;
  assign hold_s = ctl_s.hold;
  assign sdin_s = ctl_s.sdin;

  psr_gate_edge u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_s_i (tick_s),
    .hold_s_i (hold_s),
    .rise_o   (rise)
  );

  psr_stages #(.N(N)) u_stages (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (~mode_s),
    .shift_i (mode_s & rise),
    .sdin_i  (sdin_s),
    .par_i   (par_i),
    .stg_o   (stg_q)
  );

  assign sdout_o   = stg_q[N-1];
  assign sdout_n_o = ~stg_q[N-1];
endmodule

// File: rtl/psr_chk.sv
module psr_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         mode_s,
  input logic         hold_s,
  input logic         sdin_s,
  input logic         rise,
  input logic [N-1:0] stg_q,
  input logic [N-1:0] par_i,
  input logic         sdout_o,
  input logic         sdout_n_o
);
  AST_OUT_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdout_o == stg_q[N-1]) && (sdout_n_o != sdout_o)); // R1

  AST_LOAD_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_s |=> stg_q == $past(par_i)); // R3

  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s && rise) |=> stg_q == {$past(stg_q[N-2:0]), $past(sdin_s)}); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_s && !rise) |=> $stable(stg_q)); // R5

  AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_s && $past(hold_s)) |-> !rise); // R6
endmodule

bind psr_shift_reg psr_chk #(.N(N)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_s    (mode_s),
  .hold_s    (hold_s),
  .sdin_s    (sdin_s),
  .rise      (rise),
  .stg_q     (stg_q),
  .par_i     (par_i),
  .sdout_o   (sdout_o),
  .sdout_n_o (sdout_n_o)
);

// File: tb/psr_shift_reg_tb_top.sv
`timescale 1ns/1ps
module psr_shift_reg_tb_top;
  localparam int unsigned N = 8;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         mode = 1'b1;
  logic         tick = 1'b0;
  logic         hold = 1'b0;
  logic         sdin = 1'b0;
  logic [N-1:0] par = '0;
  logic         sdout;
  logic         sdout_n;

  logic [N-1:0] model = '0;
  item_t        sb_q[$];
  int           n_chk = 0;
  int           n_err = 0;
  bit           done  = 1'b0;

  always #2.5 clk = ~clk;

  psr_shift_reg #(.N(N)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .tick_i      (tick),
    .tick_hold_i (hold),
    .sdin_i      (sdin),
    .par_i       (par),
    .sdout_o     (sdout),
    .sdout_n_o   (sdout_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input string r);
    sb_q.push_back('{exp: model[N-1], req: r});
  endtask

  // monitor: compares away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk++;
        if (sdout !== it.exp || sdout_n !== ~it.exp) begin
          n_err++;
          $display("FAIL %s: sdout=%b sdout_n=%b expected %b/%b",
                   it.req, sdout, sdout_n, it.exp, ~it.exp);
        end
      end
    end
  end

  task automatic do_load(input logic [N-1:0] d);
    mode = 1'b0; par = d;
    cyc(4);
    model = d;
    push("R3");
    mode = 1'b1;
    cyc(4);
  endtask

  task automatic shift_tick(input logic b);
    sdin = b;
    cyc(3);
    tick = 1'b1;
    cyc(2);
    push("R9");                    // two edges: not yet visible
    cyc(1);
    model = {model[N-2:0], b};
    push("R4");
    tick = 1'b0;
    cyc(3);
    push("R5");                    // falling tick: hold
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      finish_run();
    end
  end

  initial begin
    cyc(3);
    push("R2");
    cyc(1);
    rst_ni = 1'b1;
    cyc(1);
    push("R2");

    // load then shift the word out, checking every bit
    do_load(8'hA5);
    for (int i = 0; i < N; i++) shift_tick(i[0]);

    // load overrides toggling ticks and serial input
    mode = 1'b0; par = 8'h3C;
    for (int i = 0; i < 4; i++) begin
      tick = ~tick; sdin = ~sdin; cyc(2);
    end
    tick = 1'b0; cyc(4);
    model = 8'h3C;
    push("R3");
    mode = 1'b1; cyc(4);

    // parallel word ignored in shift mode
    par = 8'hFF; cyc(5);
    push("R5");
    for (int i = 0; i < 3; i++) shift_tick(1'b0);
    par = 8'h00;
    for (int i = 0; i < 3; i++) shift_tick(1'b1);
    push("R5");

    // tick-hold freezes the chain
    sdin = 1'b1; cyc(3);
    tick = 1'b1; cyc(4);
    model = {model[N-2:0], 1'b1};
    push("R4");
    hold = 1'b1; sdin = 1'b0; cyc(3);
    for (int i = 0; i < 3; i++) begin
      tick = 1'b0; cyc(3);
      push("R6");
      tick = 1'b1; cyc(3);
      push("R6");
    end
    tick = 1'b0; cyc(3);
    hold = 1'b0; cyc(4);
    push("R6");

    // tick-hold rising with tick low acts as a tick
    do_load(8'h01);
    for (int i = 0; i < N-1; i++) begin
      sdin = 1'b0; cyc(3);
      hold = 1'b1; cyc(4);
      model = {model[N-2:0], 1'b0};
      push("R7");
      hold = 1'b0; cyc(4);
    end

    // load and edge in the same cycle: load wins
    do_load(8'h00);
    sdin = 1'b1; cyc(3);
    mode = 1'b0; tick = 1'b1; par = 8'h81;
    cyc(1);
    mode = 1'b1;
    cyc(4);
    model = 8'h81;
    push("R8");
    tick = 1'b0; cyc(4);
    shift_tick(1'b0);
    push("R8");

    cyc(3);
    done = 1'b1;
    finish_run();
  end
endmodule